// File: doc/BRIEF.md
# Timing-Speculation Register Bank with One-Cycle Recovery

This block is a bank of pipeline registers, each lane `WIDTH` bits wide, that can tell when its input settled too late for the main clock edge. Every lane has a main flip-flop on `clk` and a shadow capture on a delayed clock `dly_clk`. The shadow takes its sample when the delayed window closes, so it holds the value that finally arrived. If the main flop and the shadow disagree after a normal capture, the lane raises an error. On the next main edge the lane reloads itself with the shadow value through a select in front of the main flop.

While any lane is in error, a small recovery controller drops `clk_en` for one cycle. The edge inside that cycle is spent on the fix: lanes in error load their shadow values, every other lane keeps its value, and the data inputs are not taken. The producer upstream is expected to hold its data while `clk_en` is low. When no late arrival occurs, the bank acts as a plain register with no added latency, and the shadow path has no visible effect.

Top module: `tsr_bank`

## Requirements
- R1: While `rst` is high across a `clk` edge and a falling `dly_clk` edge, `q_out` becomes zero, `lane_err` and `any_err` become zero, and `clk_en` becomes 1.
- R2: With no late change, the value on lane i of `d_in` (bits `i*WIDTH +: WIDTH`) just before a `clk` rising edge appears on the same bits of `q_out` right after that edge. `lane_err` stays zero. Input changes made after the delayed window closes raise no error.
- R3: If lane i's input changes after the `clk` edge but before `dly_clk` falls, `lane_err` bit i goes high when `dly_clk` falls. It stays high through the next `clk` edge and until the following `dly_clk` fall.
- R4: On the `clk` edge after an error is raised, each erroring lane loads the late-arriving value, so `q_out` holds the correct data from then on.
- R5: `any_err` is the OR of all `lane_err` bits, and `clk_en` is its inverse.
- R6: On the stalled edge (`clk_en` low), lanes not in error keep their `q_out` value, and any change on their `d_in` is ignored until the following edge.
- R7: The stall lasts exactly one cycle. No comparison is made for the stalled edge, so all error outputs are clear and `clk_en` is 1 one cycle after they were raised.
- R8: Late arrivals on consecutive capture edges, including several lanes at once, are each detected and each corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main capture clock |
| dly_clk | input | 1 | Delayed clock; the shadow samples when it falls |
| rst | input | 1 | Synchronous active-high reset |
| d_in | input | LANES*WIDTH | Lane data inputs, lane i at bits i*WIDTH +: WIDTH |
| q_out | output | LANES*WIDTH | Registered lane outputs |
| lane_err | output | LANES | Registered per-lane mismatch flags |
| any_err | output | 1 | Registered OR of all lane flags |
| clk_en | output | 1 | Registered clock enable, low for the single recovery cycle |

## Verification
On every cycle, the assertions check four relations. The global flag and `clk_en` stay consistent with the lane flags. An error never lasts into a second cycle. No error follows a stalled edge. Clean lanes keep their value across a stalled edge. Only the directed scenarios can show that a late change actually raises the right lane's flag, that the corrected value is the late one, that on-time data passes with zero latency, and that repeated late arrivals on consecutive captures are each recovered. Each of these depends on when the stimulus moves relative to the delayed window.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  // Source chosen for a lane's main flop on a main-clock edge
  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_SHADOW = 2'd1,
    SEL_HOLD   = 2'd2
  } main_sel_e;

endpackage

// File: rtl/tsr_lane.sv
module tsr_lane
  import tsr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             dly_clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  input  logic             cap_ok,
  input  logic             stall,
  output logic [WIDTH-1:0] q,
  output logic             mismatch,
  output logic             err_q
);

  logic [WIDTH-1:0] shadow_q;
  logic [WIDTH-1:0] bit_diff;
  main_sel_e        sel;

  // Per-bit differences, OR-reduced into this lane's mismatch
  assign bit_diff = q ^ d;
  assign mismatch = cap_ok & (|bit_diff);

  always_comb begin
    if (err_q)      sel = SEL_SHADOW;
    else if (stall) sel = SEL_HOLD;
    else            sel = SEL_DATA;
  end

  // Main flop with the correction select in front of it
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (sel)
        SEL_SHADOW: q <= shadow_q;
        SEL_HOLD:   q <= q;
        default:    q <= d;
      endcase
    end
  end

  // Shadow sample and lane flag, taken as the delayed window closes
  always_ff @(negedge dly_clk) begin
    if (rst) begin
      shadow_q <= '0;
      err_q    <= 1'b0;
    end else begin
      shadow_q <= d;
      err_q    <= mismatch;
    end
  end

endmodule

// File: rtl/tsr_recovery.sv
module tsr_recovery #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             dly_clk,
  input  logic             rst,
  input  logic [LANES-1:0] mismatch,
  output logic             any_err,
  output logic             clk_en,
  output logic             cap_ok
);

  logic any_mismatch;

  assign any_mismatch = |mismatch;

  // Global flag and enable, registered with the shadows
  always_ff @(negedge dly_clk) begin
    if (rst) begin
      any_err <= 1'b0;
      clk_en  <= 1'b1;
    end else begin
      any_err <= any_mismatch;
      clk_en  <= ~any_mismatch;
    end
  end

  // Marks whether the last main edge took fresh data (not a stall edge)
  always_ff @(posedge clk) begin
    if (rst) cap_ok <= 1'b0;
    else     cap_ok <= ~any_err;
  end

endmodule

// File: rtl/tsr_bank.sv
module tsr_bank #(
  parameter int WIDTH = 16,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   dly_clk,
  input  logic                   rst,
  input  logic [LANES*WIDTH-1:0] d_in,
  output logic [LANES*WIDTH-1:0] q_out,
  output logic [LANES-1:0]       lane_err,
  output logic                   any_err,
  output logic                   clk_en
);

  localparam int BUS_W = LANES * WIDTH;

  logic [LANES-1:0] mismatch;
  logic             cap_ok;
  logic [BUS_W-1:0] q_bus;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tsr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk      (clk),
      .dly_clk  (dly_clk),
      .rst      (rst),
      .d        (d_in[i*WIDTH +: WIDTH]),
      .cap_ok   (cap_ok),
      .stall    (any_err),
      .q        (q_bus[i*WIDTH +: WIDTH]),
      .mismatch (mismatch[i]),
      .err_q    (lane_err[i])
    );
  end

  tsr_recovery #(.LANES(LANES)) u_rec (
    .clk      (clk),
    .dly_clk  (dly_clk),
    .rst      (rst),
    .mismatch (mismatch),
    .any_err  (any_err),
    .clk_en   (clk_en),
    .cap_ok   (cap_ok)
  );

  assign q_out = q_bus;

endmodule

// File: rtl/tsr_bank_chk.sv
module tsr_bank_chk #(
  parameter int WIDTH = 16,
  parameter int LANES = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES*WIDTH-1:0] q_out,
  input logic [LANES-1:0]       lane_err,
  input logic                   any_err,
  input logic                   clk_en
);

  AST_RESET_CLEARS_Q: assert property (@(posedge clk) rst |=> (q_out == '0)); // R1

  AST_GLOBAL_IS_OR: assert property (@(posedge clk) disable iff (rst)
    any_err == (|lane_err)); // R5

  AST_EN_INVERTS_ERR: assert property (@(posedge clk) disable iff (rst)
    clk_en == !any_err); // R5

  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (rst)
    any_err |=> !any_err); // R7

  AST_NO_ERR_AFTER_STALL: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> (lane_err == '0)); // R7

  for (genvar i = 0; i < LANES; i++) begin : g_hold
    AST_CLEAN_LANE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!clk_en && !lane_err[i]) |=> $stable(q_out[i*WIDTH +: WIDTH])); // R6
  end

endmodule

bind tsr_bank tsr_bank_chk #(.WIDTH(WIDTH), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .q_out    (q_out),
  .lane_err (lane_err),
  .any_err  (any_err),
  .clk_en   (clk_en)
);

// File: tb/tsr_bank_bench.sv
`timescale 1ns/1ps
module tsr_bank_bench;

  localparam int W = 16;
  localparam int L = 4;

  logic           clk = 1'b0;
  logic           dly_clk = 1'b0;
  logic           rst = 1'b1;
  logic [L*W-1:0] d_in = '0;
  logic [L*W-1:0] q_out;
  logic [L-1:0]   lane_err;
  logic           any_err;
  logic           clk_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [L*W-1:0] exp_q;

  tsr_bank #(.WIDTH(W), .LANES(L)) u_tsr_bank (
    .clk(clk), .dly_clk(dly_clk), .rst(rst), .d_in(d_in),
    .q_out(q_out), .lane_err(lane_err), .any_err(any_err), .clk_en(clk_en)
  );

  always #2 clk = ~clk;

  // Delayed clock: rises 1 ns after clk, falls 3 ns after clk
  always @(posedge clk) begin
    #1 dly_clk = 1'b1;
    #2 dly_clk = 1'b0;
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(int s, int i);
    return W'((s * 40503 + i * 7919 + 17) & 16'hFFFF);
  endfunction

  // Move to the sampling point 3.5 ns after the next main edge
  task automatic next_mid();
    @(posedge clk);
    #3.5;
  endtask

  task automatic test_reset();
    d_in = {L{16'hA5A5}};
    repeat (4) @(posedge clk);
    #3.5;
    chk("R1", "q_out", q_out, '0);
    chk("R1", "lane_err", lane_err, '0);
    chk("R1", "any_err", any_err, 0);
    chk("R1", "clk_en", clk_en, 1);
    rst = 1'b0;
  endtask

  task automatic test_on_time();
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < L; i++) d_in[i*W +: W] = pat(s, i);
      exp_q = d_in;
      next_mid();
      chk("R2", "q_out on time", q_out, exp_q);
      chk("R2", "lane_err on time", lane_err, '0);
      chk("R2", "clk_en on time", clk_en, 1);
    end
  endtask

  // One late round: lanes in mask change after the edge, inside the window
  task automatic late_round(logic [L-1:0] mask, int seed);
    logic [L*W-1:0] late_v;
    logic [L*W-1:0] other_v;
    for (int i = 0; i < L; i++) d_in[i*W +: W] = pat(seed, i);
    exp_q = d_in;
    late_v = d_in;
    other_v = d_in;
    for (int i = 0; i < L; i++) begin
      if (mask[i]) late_v[i*W +: W] = ~pat(seed, i);
      else         other_v[i*W +: W] = pat(seed + 50, i);
    end
    @(posedge clk);
    #0.5;
    d_in = late_v;
    #3;
    chk("R3", "lane_err raised", lane_err, mask);
    chk("R5", "any_err raised", any_err, 1);
    chk("R5", "clk_en low", clk_en, 0);
    chk("R2", "early capture", q_out, exp_q);
    // clean lanes present new data during the stall; it must be ignored (R6)
    d_in = other_v;
    for (int i = 0; i < L; i++) if (mask[i]) d_in[i*W +: W] = late_v[i*W +: W];
    @(posedge clk);
    #0.5;
    chk("R3", "any_err held past edge", any_err, 1);
    chk("R3", "lane_err held past edge", lane_err, mask);
    #3;
    for (int i = 0; i < L; i++) if (mask[i]) exp_q[i*W +: W] = late_v[i*W +: W];
    chk("R4", "corrected q_out, clean lanes held (R6)", q_out, exp_q);
    chk("R7", "lane_err cleared", lane_err, '0);
    chk("R7", "clk_en back", clk_en, 1);
  endtask

  task automatic test_late_single();
    late_round(4'b0010, 10);
    exp_q = d_in;
    next_mid();
    chk("R6", "held data taken after stall", q_out, exp_q);
    chk("R7", "no error after stall", lane_err, '0);
  endtask

  task automatic test_back_to_back();
    late_round(4'b1001, 20);
    late_round(4'b1001, 21);
    late_round(4'b0110, 22);
    late_round(4'b1111, 23);
    exp_q = d_in;
    next_mid();
    chk("R8", "final capture after repeated recovery", q_out, exp_q);
    chk("R8", "no residual error", any_err, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_on_time();
    test_late_single();
    test_back_to_back();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule